// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master. It works from programmable counts expressed in cycles of the block clock. There are two count pairs, one for standard speed and one for fast speed. Each pair has a high count and a low count, and a speed-select input picks one pair. A separate hold count places the moment at which the bus engine may change SDA after SCL has gone low.

The block gives the bus engine two signals:
- a registered "pull SCL low" level;
- a one-cycle SDA step strobe.

The counts are not the periods themselves, because the generator adds fixed cycles:
- The low phase lasts the low count plus one cycle.
- The high phase lasts the high count plus three cycles.

The high phase is timed only from the moment the sensed SCL line is actually high. A slave that holds SCL low therefore lengthens the period.

The counts are captured only while the controller is disabled, so a running transfer never sees them change. While the generator is disabled, or has no clocking request, SCL is released.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the generator is both enabled and asked to run, `scl_pull_low` and `sda_step` are 0.
- R2: With enable and run high, each low phase drives `scl_pull_low`=1 for exactly L+1 consecutive cycles, where L is the selected low count.
- R3: When the sensed SCL follows the release at once, each high phase keeps `scl_pull_low`=0 for exactly H+3 cycles, where H is the selected high count.
- R4: `fast_sel`=1 selects `fast_high`/`fast_low`, and `fast_sel`=0 selects `std_high`/`std_low`.
- R5: Counts, hold and speed selection are sampled only while `enable`=0. A change to them while enabled has no effect on the periods until the next disable.
- R6: The high-phase count starts only once `scl_in` is seen high. While `scl_in` stays low after the release, SCL stays released, and the released time grows by one cycle per stretched cycle.
- R7: `sda_step` pulses exactly once in each low phase. It pulses D cycles after the first low cycle, where D = min(hold count, L).
- R8: Dropping `run` lets the current period finish and then leaves SCL released. Dropping `enable` releases SCL in the next cycle.
- R9: Standard counts of 100 high and 125 low give a bus period of 229 cycles (126 low, 103 high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enabled; counts are sampled while low |
| run | input | 1 | Bus engine requests SCL clocking |
| fast_sel | input | 1 | 1 = fast-speed count pair, 0 = standard pair |
| std_high | input | CW | Standard-speed high count |
| std_low | input | CW | Standard-speed low count |
| fast_high | input | CW | Fast-speed high count |
| fast_low | input | CW | Fast-speed low count |
| hold_cnt | input | CW | SDA hold delay after SCL falls, in cycles |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| sda_step | output | 1 | One-cycle strobe: SDA may change now |

## Verification
The hardest situation to reach is a slave holding SCL low after the generator has released it. In normal operation the sensed line simply follows the drive. To create the stretch, the bench models the bus line as the inverse of the pull-low output combined with a stretch flag. It raises that flag during a low phase and clears it after a counted number of released cycles, which makes the expected released time exact. Count changes made while enabled are checked the same way: the bench compares the period measured before and after a disable.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          run,
  input  logic          fast_sel,
  input  logic [CW-1:0] std_high,
  input  logic [CW-1:0] std_low,
  input  logic [CW-1:0] fast_high,
  input  logic [CW-1:0] fast_low,
  input  logic [CW-1:0] hold_cnt,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic          sda_step
);

  localparam int KW = CW + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t           st_q;
  logic [KW-1:0] cnt_q;
  logic [CW-1:0] hi_q, lo_q, hold_q;

  wire [KW-1:0] hi_last  = {1'b0, hi_q} + KW'(1);
  wire [CW-1:0] hold_eff = (hold_q > lo_q) ? lo_q : hold_q;
  wire          lo_done  = (cnt_q == {1'b0, lo_q});
  wire          hi_done  = (cnt_q == hi_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      hold_q <= '0;
    end else if (!enable) begin
      hi_q   <= fast_sel ? fast_high : std_high;
      lo_q   <= fast_sel ? fast_low  : std_low;
      hold_q <= hold_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (run) begin
          st_q  <= S_LOW;
          cnt_q <= '0;
        end
        S_LOW: if (lo_done) begin
          st_q  <= S_WAIT;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + KW'(1);
        end
        S_WAIT: if (scl_in) begin
          st_q  <= S_HIGH;
          cnt_q <= '0;
        end
        S_HIGH: if (hi_done) begin
          st_q  <= run ? S_LOW : S_IDLE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + KW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign scl_pull_low = (st_q == S_LOW);
  assign sda_step     = (st_q == S_LOW) && (cnt_q == {1'b0, hold_eff});

  a_r2_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> (cnt_q <= {1'b0, lo_q}));

  a_r3_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HIGH) |-> (cnt_q <= hi_last));

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(lo_q) && $stable(hi_q) && $stable(hold_q)));

  a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !scl_in) |=> !scl_pull_low);

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    sda_step |=> !sda_step);

  a_r8_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !sda_step));

endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // fields: fast, std_h, std_l, fast_h, fast_l, hold, exp_low, exp_high, exp_sda
  localparam int VEC [NV][9] = '{
    '{0,   4,   6,  9,  9,  2,   7,   7,  2},
    '{1,   4,   6,  9,  9,  2,  10,  12,  2},
    '{0,   0,   0,  9,  9,  0,   1,   3,  0},
    '{0,   3,   2,  9,  9,  5,   3,   6,  2},
    '{1,   7,   7,  1, 12, 12,  13,   4, 12},
    '{0, 100, 125,  5,  5, 28, 126, 103, 28},
    '{1,   7,   7, 20,  3,  1,   4,  23,  1}
  };

  logic clk = 0, rst_n = 0, enable = 0, run = 0, fast_sel = 0, stretch = 0;
  logic [15:0] std_high = 0, std_low = 0, fast_high = 0, fast_low = 0, hold_cnt = 0;
  logic scl_pull_low, sda_step, scl_in;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_in = ~scl_pull_low & ~stretch;

  scl_timing_gen #(.CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .fast_sel(fast_sel),
    .std_high(std_high), .std_low(std_low), .fast_high(fast_high), .fast_low(fast_low),
    .hold_cnt(hold_cnt), .scl_in(scl_in), .scl_pull_low(scl_pull_low), .sda_step(sda_step)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int f, input int sh, input int sl, input int fh, input int fl, input int h);
    @(negedge clk);
    enable = 0;
    fast_sel = f[0]; std_high = 16'(sh); std_low = 16'(sl);
    fast_high = 16'(fh); fast_low = 16'(fl); hold_cnt = 16'(h);
    @(negedge clk); @(negedge clk);
    enable = 1; run = 1;
  endtask

  task automatic measure(input int st_n, output int lo, output int hi, output int sda);
    int nstep = 0;
    lo = 0; hi = 0; sda = -1;
    @(negedge clk);
    while (scl_pull_low) @(negedge clk);
    while (!scl_pull_low) @(negedge clk);
    if (st_n > 0) stretch = 1;
    while (scl_pull_low) begin
      if (sda_step) begin sda = lo; nstep++; end
      lo++;
      @(negedge clk);
    end
    while (!scl_pull_low) begin
      hi++;
      if (hi == st_n) stretch = 0;
      @(negedge clk);
    end
    if (nstep != 1) sda = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lo, hi, sda, seen;
    repeat (3) @(negedge clk);
    chk("R1 reset scl", int'(scl_pull_low), 0);
    chk("R1 reset step", int'(sda_step), 0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", int'(scl_pull_low), 0);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
      measure(0, lo, hi, sda);
      chk($sformatf("R2/R4/R9 low v%0d", i), lo, VEC[i][6]);
      chk($sformatf("R3/R4/R9 high v%0d", i), hi, VEC[i][7]);
      chk($sformatf("R7 sda step v%0d", i), sda, VEC[i][8]);
    end

    // R5: change while enabled has no effect until next disable
    setup(0, 4, 6, 9, 9, 2);
    measure(0, lo, hi, sda);
    @(negedge clk); std_low = 20; std_high = 1;
    measure(0, lo, hi, sda);
    chk("R5 low unchanged while enabled", lo, 7);
    chk("R5 high unchanged while enabled", hi, 7);
    setup(0, 1, 20, 9, 9, 2);
    measure(0, lo, hi, sda);
    chk("R5 low after re-enable", lo, 21);

    // R6: slave stretch
    setup(0, 4, 6, 9, 9, 2);
    measure(10, lo, hi, sda);
    chk("R6 stretched high", hi, 4 + 12);
    measure(0, lo, hi, sda);
    chk("R6 normal after stretch", hi, 7);

    // R8: run dropped
    @(negedge clk);
    while (!scl_pull_low) @(negedge clk);
    run = 0;
    while (scl_pull_low) @(negedge clk);
    seen = 0;
    for (int k = 0; k < 400; k++) begin
      if (scl_pull_low) seen++;
      @(negedge clk);
    end
    chk("R8 released after run drop", seen, 0);

    // R8: enable dropped mid low phase
    run = 1;
    while (!scl_pull_low) @(negedge clk);
    @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk("R8 release after disable", int'(scl_pull_low), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule